// File: doc/BRIEF.md
# SCSI Initiator Command and Interrupt Front End

This block is the host-facing register unit of a simple SCSI initiator controller. A byte-wide host bus reaches sixteen register locations. Several locations mean one thing when read and another when written, so the block keeps a read-side copy and a write-side copy of every location. The host writes one-byte commands. The block decodes each command and updates the status, interrupt-cause, sequence-step and FIFO-flag registers. A single level interrupt output follows the pending flag held in bit 7 of the status register.

The register offset is the host byte address shifted right by a programmable amount. This lets the block sit on buses where registers are spaced 1, 2, 4 or more bytes apart. A mask input tells the block which targets are present on the bus. Selecting a missing target ends in a defined disconnect result. Selecting a present target ends in a command-phase-complete result. A transfer-information command pulses a start strobe toward a separate transfer engine. That engine reports back with a one-cycle done strobe.

Reading the interrupt-cause register acknowledges the interrupt. The bus-reset report can be kept quiet by a configuration bit.

Top module: `scsi_ini_front`

## Requirements
- R1: After reset, every readable location reads 0x00, except two. Configuration location 8 reads 0x07, and location 0xE reads 0x04 as a chip-type code. The irq output is low.
- R2: A write to location 8 or to 0xB..0xF is mirrored, so the same location reads the written byte back. A write to 0, 1, 2, 4..7, 9 or 0xA is kept on the write side only and does not change what that location reads.
- R3: The register offset is bits 3:0 of the host address shifted right by the `shift_sel` input.
- R4: Command opcode 0x03 (bus reset) loads 0x80 into the interrupt-cause register (location 5). It sets status bit 7 and irq only when bit 6 of the written configuration byte at location 8 is 0.
- R5: Reading location 5 returns its current value. In the next cycle it clears status bits 7, 6 and 5 and drops irq. Status sits at location 4.
- R6: Opcodes 0x42 and 0x43 (select) take the target number from bits 2:0 of the byte last written to location 4. If that target's bit in `tgt_present` is 0, the results are: status 0x80, interrupt-cause 0x20, sequence step (location 6) 0, and irq high.
- R7: Selecting a present target gives interrupt-cause 0x18, sequence step 4 and irq high. Status becomes 0x90 for opcode 0x42 and 0x92 for opcode 0x43.
- R8: The following commands never raise irq. Opcode 0x01 (flush) sets interrupt-cause to 0x08 and clears sequence step and FIFO flags (location 7). Opcode 0x44 (enable selection) clears interrupt-cause.
- R9: An opcode in bits 6:0 outside the set {0x00, 0x01, 0x02, 0x03, 0x10, 0x11, 0x12, 0x1A, 0x42, 0x43, 0x44} changes no status, interrupt-cause or step register. It pulses `cmd_err` for exactly one cycle. Every command byte reads back at location 3.
- R10: Opcode 0x10 pulses `xfer_start` for one cycle, and `xfer_dma` takes command bit 7. When bit 7 is set, the command copies the write-side bytes of locations 0 and 1 into their readable copies. A later `xfer_done` pulse has these results: status bit 4 set, interrupt-cause 0x10, sequence step 0, locations 0, 1 and 7 read 0, and irq raised.
- R11: Any write to location 0 or 1 clears status bit 4. Status bit 4 is the count-done bit.
- R12: Opcode 0x02 (chip reset) returns every register to the R1 values.
- R13: Opcode 0x11 sets status bits 2:0 to 7, FIFO flags to 2 and interrupt-cause to 0x08, and raises irq. Opcode 0x12 sets interrupt-cause to 0x20, sequence step to 0 and FIFO flags to 2, and raises irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr | input | ADDR_W (8) | Host byte address |
| shift_sel | input | SHIFT_W (2) | Right shift applied to addr to form the offset |
| wr_en | input | 1 | Host write strobe, one byte per cycle |
| rd_en | input | 1 | Host read strobe; its side effects land at the clock edge |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Readable copy of the addressed location |
| tgt_present | input | NUM_TGT (8) | One bit per target, 1 when the target answers selection |
| xfer_done | input | 1 | One-cycle strobe from the transfer engine |
| irq | output | 1 | Level interrupt, equal to status bit 7 |
| cmd_err | output | 1 | One-cycle pulse after an unrecognised opcode |
| xfer_start | output | 1 | One-cycle pulse after a transfer-information command |
| xfer_dma | output | 1 | DMA-mode bit of the last command |

## Verification
Selection is tried with the chosen target both absent and present, and with both select opcodes. This separates the disconnect outcome from the command-done outcome and tells the two status codes apart. Bus reset is issued with the configuration mask bit clear and then set. This checks that the cause register always loads while irq rises only in the unmasked case. Mirrored and write-only locations are written and read back under three shift values, which exposes any mix-up of the read-side and write-side copies or of the offset arithmetic. A bad opcode, a DMA transfer with a done strobe, and the acknowledge read each check that the right registers change and that the others stay put.

// File: rtl/scsi_front_pkg.sv
package scsi_front_pkg;
  localparam int REGS  = 16;
  localparam int OFS_W = 4;

  localparam int L_CNT0  = 0;
  localparam int L_CNT1  = 1;
  localparam int L_CMD   = 3;
  localparam int L_STAT  = 4;
  localparam int L_CAUSE = 5;
  localparam int L_STEP  = 6;
  localparam int L_FLAGS = 7;
  localparam int L_CONF  = 8;
  localparam int L_CHIP  = 14;

  localparam logic [7:0] CAUSE_FDONE = 8'h08;
  localparam logic [7:0] CAUSE_BSERV = 8'h10;
  localparam logic [7:0] CAUSE_DISC  = 8'h20;
  localparam logic [7:0] CAUSE_BRST  = 8'h80;
  localparam logic [7:0] STEP_CMDOK  = 8'h04;
  localparam logic [7:0] CONF_RST    = 8'h07;
  localparam logic [7:0] CHIP_CODE   = 8'h04;

  typedef enum logic [3:0] {
    OP_NOP, OP_FLUSH, OP_CHIPRST, OP_BUSRST, OP_XFER, OP_ICC,
    OP_MSGOK, OP_ATN, OP_SELA, OP_SELAS, OP_ENSEL, OP_BAD
  } op_e;

  typedef enum logic [2:0] {
    WK_COUNT, WK_FIFO, WK_CMD, WK_WONLY, WK_MIRROR
  } wkind_e;
endpackage

// File: rtl/scsi_rst_sync.sv
module scsi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/scsi_addr_map.sv
module scsi_addr_map
  import scsi_front_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int SHIFT_W = 2
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [SHIFT_W-1:0] shift_sel,
  output logic [OFS_W-1:0]   off,
  output wkind_e             wkind
);
  logic [ADDR_W-1:0] shifted;

  always_comb begin
    shifted = addr >> shift_sel;
    off     = shifted[OFS_W-1:0];
  end

  always_comb begin
    case (off)
      4'h0, 4'h1: wkind = WK_COUNT;
      4'h2:       wkind = WK_FIFO;
      4'h3:       wkind = WK_CMD;
      4'h8, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF: wkind = WK_MIRROR;
      default:    wkind = WK_WONLY;
    endcase
  end
endmodule

// File: rtl/scsi_cmd_dec.sv
module scsi_cmd_dec
  import scsi_front_pkg::*;
(
  input  logic [7:0] cmd_byte,
  output op_e        op,
  output logic       dma_bit
);
  always_comb begin
    dma_bit = cmd_byte[7];
    case (cmd_byte[6:0])
      7'h00:   op = OP_NOP;
      7'h01:   op = OP_FLUSH;
      7'h02:   op = OP_CHIPRST;
      7'h03:   op = OP_BUSRST;
      7'h10:   op = OP_XFER;
      7'h11:   op = OP_ICC;
      7'h12:   op = OP_MSGOK;
      7'h1A:   op = OP_ATN;
      7'h42:   op = OP_SELA;
      7'h43:   op = OP_SELAS;
      7'h44:   op = OP_ENSEL;
      default: op = OP_BAD;
    endcase
  end
endmodule

// File: rtl/scsi_reg_bank.sv
module scsi_reg_bank
  import scsi_front_pkg::*;
#(
  parameter int NUM_TGT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OFS_W-1:0]   off,
  input  wkind_e             wkind,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [7:0]         wr_data,
  input  op_e                op,
  input  logic               dma_bit,
  input  logic [NUM_TGT-1:0] tgt_present,
  input  logic               xfer_done,
  output logic [7:0]         rd_data,
  output logic               irq,
  output logic               cmd_err,
  output logic               xfer_start,
  output logic               xfer_dma
);
  localparam int TGT_W = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;

  logic [7:0] rreg_q [REGS];
  logic [7:0] rreg_d [REGS];
  logic [7:0] wreg_q [REGS];
  logic [7:0] wreg_d [REGS];
  logic       err_q, err_d, start_q, start_d, dma_q, dma_d;
  logic       is_cmd, rd_ack, raise, chip_rst, tgt_ok;
  logic [TGT_W-1:0] tgt_id;

  assign is_cmd = wr_en && (wkind == WK_CMD);
  assign rd_ack = rd_en && (off == OFS_W'(L_CAUSE));
  assign tgt_id = wreg_q[L_STAT][TGT_W-1:0];
  assign tgt_ok = (int'(tgt_id) < NUM_TGT) && tgt_present[tgt_id];

  always_comb begin
    for (int i = 0; i < REGS; i++) begin
      rreg_d[i] = rreg_q[i];
      wreg_d[i] = wreg_q[i];
    end
    err_d    = 1'b0;
    start_d  = 1'b0;
    dma_d    = dma_q;
    raise    = 1'b0;
    chip_rst = 1'b0;

    if (rd_ack) rreg_d[L_STAT][7:5] = 3'b000;

    if (xfer_done) begin
      rreg_d[L_STAT][4] = 1'b1;
      rreg_d[L_CAUSE]   = CAUSE_BSERV;
      rreg_d[L_STEP]    = 8'h00;
      rreg_d[L_FLAGS]   = 8'h00;
      rreg_d[L_CNT0]    = 8'h00;
      rreg_d[L_CNT1]    = 8'h00;
      raise             = 1'b1;
    end

    if (wr_en) begin
      wreg_d[off] = wr_data;
      case (wkind)
        WK_COUNT:  rreg_d[L_STAT][4] = 1'b0;
        WK_MIRROR: rreg_d[off] = wr_data;
        default: ;
      endcase
    end

    if (is_cmd) begin
      rreg_d[L_CMD] = wr_data;
      dma_d         = dma_bit;
      if (dma_bit) begin
        rreg_d[L_CNT0] = wreg_q[L_CNT0];
        rreg_d[L_CNT1] = wreg_q[L_CNT1];
      end
      case (op)
        OP_FLUSH: begin
          rreg_d[L_CAUSE] = CAUSE_FDONE;
          rreg_d[L_STEP]  = 8'h00;
          rreg_d[L_FLAGS] = 8'h00;
        end
        OP_CHIPRST: chip_rst = 1'b1;
        OP_BUSRST: begin
          rreg_d[L_CAUSE] = CAUSE_BRST;
          if (!wreg_q[L_CONF][6]) raise = 1'b1;
        end
        OP_XFER: begin
          rreg_d[L_STAT][4] = 1'b0;
          start_d           = 1'b1;
        end
        OP_ICC: begin
          rreg_d[L_STAT][2:0] = 3'b111;
          rreg_d[L_FLAGS]     = 8'h02;
          rreg_d[L_CAUSE]     = CAUSE_FDONE;
          raise               = 1'b1;
        end
        OP_MSGOK: begin
          rreg_d[L_FLAGS] = 8'h02;
          rreg_d[L_CAUSE] = CAUSE_DISC;
          rreg_d[L_STEP]  = 8'h00;
          raise           = 1'b1;
        end
        OP_SELA, OP_SELAS: begin
          if (tgt_ok) begin
            rreg_d[L_STAT]  = (op == OP_SELAS) ? 8'h12 : 8'h10;
            rreg_d[L_CAUSE] = CAUSE_BSERV | CAUSE_FDONE;
            rreg_d[L_STEP]  = STEP_CMDOK;
          end else begin
            rreg_d[L_STAT]  = 8'h00;
            rreg_d[L_CAUSE] = CAUSE_DISC;
            rreg_d[L_STEP]  = 8'h00;
          end
          raise = 1'b1;
        end
        OP_ENSEL: rreg_d[L_CAUSE] = 8'h00;
        OP_BAD:   err_d = 1'b1;
        default: ;
      endcase
    end

    if (raise) rreg_d[L_STAT][7] = 1'b1;

    if (chip_rst) begin
      for (int i = 0; i < REGS; i++) begin
        rreg_d[i] = 8'h00;
        wreg_d[i] = 8'h00;
      end
      rreg_d[L_CONF] = CONF_RST;
      rreg_d[L_CHIP] = CHIP_CODE;
      dma_d          = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REGS; i++) begin
        rreg_q[i] <= 8'h00;
        wreg_q[i] <= 8'h00;
      end
      rreg_q[L_CONF] <= CONF_RST;
      rreg_q[L_CHIP] <= CHIP_CODE;
      err_q   <= 1'b0;
      start_q <= 1'b0;
      dma_q   <= 1'b0;
    end else begin
      for (int i = 0; i < REGS; i++) begin
        rreg_q[i] <= rreg_d[i];
        wreg_q[i] <= wreg_d[i];
      end
      err_q   <= err_d;
      start_q <= start_d;
      dma_q   <= dma_d;
    end
  end

  assign rd_data    = rreg_q[off];
  assign irq        = rreg_q[L_STAT][7];
  assign cmd_err    = err_q;
  assign xfer_start = start_q;
  assign xfer_dma   = dma_q;

  a_r5_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack && !wr_en && !xfer_done |=> !irq);

  a_r4_masked_bus_reset: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd && op == OP_BUSRST && wreg_q[L_CONF][6] && !irq && !xfer_done
    |=> !irq && rd_data == rd_data);

  a_r4_bus_reset_raises: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd && op == OP_BUSRST && !wreg_q[L_CONF][6] |=> irq);

  a_r6_absent_disconnect: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd && (op == OP_SELA || op == OP_SELAS) && !tgt_ok
    |=> irq && rreg_q[L_CAUSE] == CAUSE_DISC);

  a_r9_bad_opcode_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd && op == OP_BAD |=> cmd_err);

  a_r9_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err && !(is_cmd && op == OP_BAD) |=> !cmd_err);

  a_r10_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd && op == OP_XFER |=> xfer_start);

  a_r8_flush_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd && (op == OP_FLUSH || op == OP_ENSEL) && !irq && !xfer_done |=> !irq);
endmodule

// File: rtl/scsi_ini_front.sv
module scsi_ini_front
  import scsi_front_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int SHIFT_W = 2,
  parameter int NUM_TGT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [SHIFT_W-1:0] shift_sel,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [7:0]         wr_data,
  output logic [7:0]         rd_data,
  input  logic [NUM_TGT-1:0] tgt_present,
  input  logic               xfer_done,
  output logic               irq,
  output logic               cmd_err,
  output logic               xfer_start,
  output logic               xfer_dma
);
  logic             rst_sync_n;
  logic [OFS_W-1:0] off;
  wkind_e           wkind;
  op_e              op;
  logic             dma_bit;

  scsi_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  scsi_addr_map #(.ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)) u_map (
    .addr      (addr),
    .shift_sel (shift_sel),
    .off       (off),
    .wkind     (wkind)
  );

  scsi_cmd_dec u_dec (
    .cmd_byte (wr_data),
    .op       (op),
    .dma_bit  (dma_bit)
  );

  scsi_reg_bank #(.NUM_TGT(NUM_TGT)) u_bank (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .off         (off),
    .wkind       (wkind),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .wr_data     (wr_data),
    .op          (op),
    .dma_bit     (dma_bit),
    .tgt_present (tgt_present),
    .xfer_done   (xfer_done),
    .rd_data     (rd_data),
    .irq         (irq),
    .cmd_err     (cmd_err),
    .xfer_start  (xfer_start),
    .xfer_dma    (xfer_dma)
  );
endmodule

// File: tb/test_scsi_ini_front.sv
module test_scsi_ini_front;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] addr;
  logic [1:0] shift_sel;
  logic       wr_en, rd_en, xfer_done;
  logic [7:0] wr_data, rd_data;
  logic [7:0] tgt_present;
  logic       irq, cmd_err, xfer_start, xfer_dma;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  scsi_ini_front i_scsi_ini_front (
    .clk(clk), .rst_n(rst_n), .addr(addr), .shift_sel(shift_sel),
    .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
    .tgt_present(tgt_present), .xfer_done(xfer_done), .irq(irq),
    .cmd_err(cmd_err), .xfer_start(xfer_start), .xfer_dma(xfer_dma)
  );

  // monitor: pops expected read bytes and compares mid-cycle
  always @(negedge clk) begin
    if (rd_en && rst_n) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL scoreboard: read with no expected item, actual=%02h", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          bad++;
          $display("FAIL %s: read actual=%02h expected=%02h", t, rd_data, e);
        end
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string t);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", t, act, exp);
    end
  endtask

  // drivers: entered just after a rising edge, leave just after the next one
  task automatic wr(input logic [3:0] ofs, input logic [7:0] d);
    shift_sel = 2'd0; addr = {4'h0, ofs}; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_sh(input logic [7:0] a, input logic [1:0] sh,
                       input logic [7:0] e, input string t);
    shift_sel = sh; addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] ofs, input logic [7:0] e, input string t);
    rd_sh({4'h0, ofs}, 2'd0, e, t);
  endtask

  task automatic done_pulse();
    xfer_done = 1'b1;
    @(posedge clk); #1;
    xfer_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = 8'h00; shift_sel = 2'd0; wr_en = 1'b0; rd_en = 1'b0;
    wr_data = 8'h00; xfer_done = 1'b0; tgt_present = 8'hF7;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1 reset values
    chk(irq, 1'b0, "R1 irq");
    rd(4'h8, 8'h07, "R1 conf");
    rd(4'hE, 8'h04, "R1 chip code");
    rd(4'h4, 8'h00, "R1 status");
    rd(4'h5, 8'h00, "R1 cause");

    // R2 mirrored vs write-only, R3 shift
    wr(4'hB, 8'h5A);
    rd(4'hB, 8'h5A, "R2 mirror");
    wr(4'h6, 8'h33);
    rd(4'h6, 8'h00, "R2 write-only step");
    rd_sh(8'h2C, 2'd2, 8'h5A, "R3 shift2");
    rd_sh(8'h16, 2'd1, 8'h5A, "R3 shift1");

    // R4/R5 bus reset unmasked, then acknowledge
    wr(4'h3, 8'h03);
    chk(irq, 1'b1, "R4 raise");
    rd(4'h4, 8'h80, "R4 status");
    rd(4'h5, 8'h80, "R4 cause");
    chk(irq, 1'b0, "R5 ack");
    rd(4'h4, 8'h00, "R5 status cleared");

    // R4 masked
    wr(4'h8, 8'h47);
    wr(4'h3, 8'h03);
    chk(irq, 1'b0, "R4 masked");
    rd(4'h5, 8'h80, "R4 masked cause");
    wr(4'h8, 8'h07);

    // R6 absent target 3
    wr(4'h4, 8'h03);
    wr(4'h3, 8'h42);
    chk(irq, 1'b1, "R6 irq");
    rd(4'h4, 8'h80, "R6 status");
    rd(4'h6, 8'h00, "R6 step");
    rd(4'h5, 8'h20, "R6 cause");

    // R7 present target 1
    wr(4'h4, 8'h01);
    wr(4'h3, 8'h42);
    chk(irq, 1'b1, "R7 irq");
    rd(4'h4, 8'h90, "R7 status sel");
    rd(4'h6, 8'h04, "R7 step");
    rd(4'h5, 8'h18, "R7 cause");
    wr(4'h3, 8'h43);
    rd(4'h4, 8'h92, "R7 status sel-stop");
    rd(4'h5, 8'h18, "R7 cause stop");

    // R8 flush and enable selection
    wr(4'h7, 8'h55);
    wr(4'h3, 8'h01);
    chk(irq, 1'b0, "R8 flush no irq");
    rd(4'h5, 8'h08, "R8 flush cause");
    rd(4'h6, 8'h00, "R8 flush step");
    rd(4'h7, 8'h00, "R8 flush flags");
    wr(4'h3, 8'h44);
    chk(cmd_err, 1'b0, "R9 valid no err");
    rd(4'h5, 8'h00, "R8 ensel cause");

    // R12 chip reset
    wr(4'h3, 8'h02);
    rd(4'h4, 8'h00, "R12 status");
    rd(4'h8, 8'h07, "R12 conf");
    rd(4'hE, 8'h04, "R12 chip code");
    rd(4'hB, 8'h00, "R12 mirror cleared");

    // R13 command complete and message accepted
    wr(4'h3, 8'h11);
    chk(irq, 1'b1, "R13 icc irq");
    rd(4'h4, 8'h87, "R13 icc status");
    rd(4'h7, 8'h02, "R13 icc flags");
    rd(4'h5, 8'h08, "R13 icc cause");
    wr(4'h3, 8'h12);
    chk(irq, 1'b1, "R13 msg irq");
    rd(4'h6, 8'h00, "R13 msg step");
    rd(4'h7, 8'h02, "R13 msg flags");
    rd(4'h5, 8'h20, "R13 msg cause");

    // R9 bad opcode
    wr(4'h3, 8'h55);
    chk(cmd_err, 1'b1, "R9 err pulse");
    rd(4'h3, 8'h55, "R9 cmd readback");
    chk(cmd_err, 1'b0, "R9 err one cycle");
    rd(4'h5, 8'h20, "R9 cause untouched");
    rd(4'h4, 8'h07, "R9 status untouched");

    // R10 DMA transfer and done
    wr(4'h3, 8'h02);
    wr(4'h0, 8'h34);
    wr(4'h1, 8'h12);
    rd(4'h0, 8'h00, "R2 count write-only");
    wr(4'h3, 8'h90);
    chk(xfer_start, 1'b1, "R10 start");
    chk(xfer_dma, 1'b1, "R10 dma");
    rd(4'h0, 8'h34, "R10 count lo reload");
    chk(xfer_start, 1'b0, "R10 start one cycle");
    rd(4'h1, 8'h12, "R10 count mid reload");
    rd(4'h4, 8'h00, "R10 status before done");
    done_pulse();
    chk(irq, 1'b1, "R10 done irq");
    rd(4'h4, 8'h90, "R10 done status");
    rd(4'h5, 8'h10, "R10 done cause");
    rd(4'h0, 8'h00, "R10 count cleared");
    rd(4'h6, 8'h00, "R10 step");

    // R11 count write clears count-done bit
    rd(4'h4, 8'h10, "R11 before");
    wr(4'h1, 8'h00);
    rd(4'h4, 8'h00, "R11 after");

    @(posedge clk); #1;
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: actual=%0d leftover expected=0", exp_q.size());
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule